// File: doc/BRIEF.md
# Radio TX/RX Turnaround Sequencer

This block drives the transmitter enable and the receiver enable of a packet radio from a few command bits that a host writes through a one-word write port. A transmit start turns the transmitter on at once. An optional wait-for-reply request makes the block drop the transmitter when the frame is done and bring up the receiver by itself, after a programmable gap measured in clock cycles. A receive command turns the receiver on at once, or, with the timed option, holds off and turns it on early enough that the warm-up ends exactly when an internal free-running system timer reaches a programmed timestamp. A timestamp that can no longer be met is reported with a one-cycle late flag. A force-idle command abandons whatever is in progress.

The command bits read back on `ctrl_rd` and clear themselves at defined events, so the host can poll them. `tx_done` and `rx_done` come from the modem and end the transmit and the receive phases. The receiver becomes usable `WARM_CYC` clocks after its enable rises, which `rx_ready` shows. `rx_on_evt` marks the first receive cycle for interrupt logic.

Top module: `trx_turnaround_seq`

## Requirements
- R1: `wr_data` bit 0 requests a transmit. With the block idle, `tx_en` rises one clock after the edge that samples the write, and `ctrl_rd` bit 0 reads 1 between those edges and clears on the edge where `tx_en` rises. A `tx_done` sampled at edge t drops `tx_en` at edge t.
- R2: `wr_data` bit 1 (wait for reply) is latched only from a write that also has bit 0 set. In any other write it is ignored: `ctrl_rd` bit 1 stays 0 and no receive follows the transmit.
- R3: With the reply wait armed, a `tx_done` sampled at edge t drops `tx_en` at edge t, and `rx_en` rises at edge t+1+D. D is `resp_dly` sampled at edge t. With D = 0 the receiver comes on at edge t+1.
- R4: `ctrl_rd` bit 1 reads 1 from the write until the edge on which `rx_en` rises, and reads 0 from that edge on.
- R5: `wr_data` bit 2 without bit 3 requests an immediate receive. With the block idle, `rx_en` rises one clock after the write edge, and `ctrl_rd` bit 2 clears on that same edge.
- R6: `rx_ready` rises `WARM_CYC` edges after `rx_en` rises. It is never high without `rx_en`. A `rx_done` sampled at edge r drops both at edge r.
- R7: `wr_data` bits 2 and 3 written together request a timed receive. `sys_time` is 0 after reset and adds 1 on every clock. The block stays idle, then raises `rx_en` so that `rx_ready` rises on the edge where `sys_time` becomes `rx_time`.
- R8: A timed receive is accepted one clock after its write edge. Let s be `sys_time` just before that acceptance edge. If `rx_time` < s + `WARM_CYC` + 2, `late_evt` pulses for the cycle after acceptance, the receiver stays off, and `ctrl_rd` bits 2 and 3 clear.
- R9: `wr_data` bit 4 forces idle. On the edge that samples it, `tx_en`, `rx_en`, `rx_ready` and all four `ctrl_rd` bits go low, and any pending gap or timed wait is dropped. The other bits of that same write are ignored.
- R10: After reset, both enables, `rx_ready` and `ctrl_rd` are 0. `tx_en` and `rx_en` are never high together, and at least one cycle with both low separates them.
- R11: `rx_on_evt` is high for exactly the first cycle of each receive period.
- R12: A command written while the block is busy stays pending and is taken on the first idle cycle, with transmit ahead of receive. A receive queued behind a transmit starts one clock after `tx_en` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 5 | Command bits: 0 transmit, 1 wait for reply, 2 receive, 3 timed receive, 4 force idle |
| resp_dly | input | DLY_W | Gap in clocks from transmit end to receiver turn-on |
| rx_time | input | TIME_W | Timestamp at which a timed receive must be ready |
| tx_done | input | 1 | Transmit finished |
| rx_done | input | 1 | Receive finished |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| rx_ready | output | 1 | Receiver warm-up complete |
| rx_on_evt | output | 1 | One-cycle pulse at receive entry |
| late_evt | output | 1 | One-cycle pulse when a timed receive is already too late |
| ctrl_rd | output | 4 | Pending command bits 0 to 3, same positions as `wr_data` |
| sys_time | output | TIME_W | Free-running system time |

## Verification
The bench builds the block with `WARM_CYC` = 8, `DLY_W` = 8 and a full 40-bit timer. With a short warm-up, the full receive sequence runs to `rx_ready` and back within a few dozen cycles. It also allows a receive to end before the warm-up finishes. Timed receives can be placed exactly on the lateness boundary and one cycle past it, and a reply gap of 20 clocks leaves room to force idle in the middle of the countdown.

// File: rtl/trx_pkg.sv
// Shared definitions for the turnaround sequencer: command bit positions
// and sequencer states. Assumes a five-bit command word.
package trx_pkg;

    localparam int CMD_W     = 5;
    localparam int RB_W      = 4;
    localparam int CB_TX     = 0;
    localparam int CB_WAIT   = 1;
    localparam int CB_RX     = 2;
    localparam int CB_RXTIME = 3;
    localparam int CB_IDLE   = 4;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_TX    = 3'd1,
        ST_GAP   = 3'd2,
        ST_TWAIT = 3'd3,
        ST_RX    = 3'd4
    } trx_state_t;

endpackage

// File: rtl/trx_systime.sv
// Free-running system time counter. Cleared by reset, then advances by one
// every clock. Wrap-around is not expected within the life of a command.
module trx_systime #(
    parameter int TIME_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [TIME_W-1:0] now
);

    // Advance the time base
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now <= '0;
        end else begin
            now <= now + TIME_W'(1);
        end
    end

endmodule

// File: rtl/trx_cmd_bits.sv
// Holds the host command bits and clears each at its own event. A force-idle
// write clears everything and masks the other bits of the same write. Setting
// wins over clearing in the same cycle. Assumes the accept and receive-entry
// strobes come from the sequencer in the same cycle as the transition.
module trx_cmd_bits
    import trx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wr_data,
    input  logic             acc_tx,
    input  logic             acc_rx,
    input  logic             rx_enter,
    output logic             force_now,
    output logic             tx_pend,
    output logic             wait_pend,
    output logic             rx_pend,
    output logic             rxt_pend
);

    logic set_tx;
    logic set_wait;
    logic set_rx;

    // Decode which bits the current write sets
    always_comb begin
        force_now = wr_en && wr_data[CB_IDLE];
        set_tx    = wr_en && !wr_data[CB_IDLE] && wr_data[CB_TX];
        set_wait  = set_tx && wr_data[CB_WAIT];
        set_rx    = wr_en && !wr_data[CB_IDLE] && wr_data[CB_RX];
    end

    // Transmit request: clears when the sequencer takes it
    always_ff @(posedge clk) begin
        if (!rst_n || force_now) begin
            tx_pend <= 1'b0;
        end else if (set_tx) begin
            tx_pend <= 1'b1;
        end else if (acc_tx) begin
            tx_pend <= 1'b0;
        end
    end

    // Reply wait: clears when the receiver comes on
    always_ff @(posedge clk) begin
        if (!rst_n || force_now) begin
            wait_pend <= 1'b0;
        end else if (set_wait) begin
            wait_pend <= 1'b1;
        end else if (rx_enter) begin
            wait_pend <= 1'b0;
        end
    end

    // Receive request and its timed qualifier: clear on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n || force_now) begin
            rx_pend  <= 1'b0;
            rxt_pend <= 1'b0;
        end else if (set_rx) begin
            rx_pend  <= 1'b1;
            rxt_pend <= wr_data[CB_RXTIME];
        end else if (acc_rx) begin
            rx_pend  <= 1'b0;
            rxt_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/trx_warmup.sv
// Counts the receiver warm-up. Ready rises WARM_CYC edges after rx_on rises
// and is gated by rx_on so it falls together with it. A zero warm-up makes
// ready follow rx_on directly.
module trx_warmup #(
    parameter int WARM_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_on,
    output logic ready
);

    generate
        if (WARM_CYC == 0) begin : g_nowarm
            // No warm-up: ready as soon as enabled
            always_comb ready = rx_on;
        end else begin : g_warm
            localparam int CNT_W = $clog2(WARM_CYC + 1);
            logic [CNT_W-1:0] cnt;
            logic             rdy_q;

            // Count enabled cycles until the warm-up is over
            always_ff @(posedge clk) begin
                if (!rst_n || !rx_on) begin
                    cnt   <= '0;
                    rdy_q <= 1'b0;
                end else if (!rdy_q) begin
                    if (cnt == CNT_W'(WARM_CYC - 1)) begin
                        rdy_q <= 1'b1;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
            end

            // Drop ready in the same cycle as the enable
            always_comb ready = rdy_q && rx_on;
        end
    endgenerate

endmodule

// File: rtl/trx_seq_fsm.sv
// Sequencer for the transmitter and receiver enables. Accepts commands only
// when idle (transmit first), performs the automatic turnaround with its
// reply gap, and schedules timed receives against the system time. Assumes
// the pending bits come from trx_cmd_bits and that time does not wrap.
module trx_seq_fsm
    import trx_pkg::*;
#(
    parameter int TIME_W   = 40,
    parameter int DLY_W    = 16,
    parameter int WARM_CYC = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              force_now,
    input  logic              tx_pend,
    input  logic              wait_pend,
    input  logic              rx_pend,
    input  logic              rxt_pend,
    input  logic              tx_done,
    input  logic              rx_done,
    input  logic [DLY_W-1:0]  resp_dly,
    input  logic [TIME_W-1:0] rx_time,
    input  logic [TIME_W-1:0] now,
    output logic              acc_tx,
    output logic              acc_rx,
    output logic              rx_enter,
    output logic              tx_en,
    output logic              rx_en,
    output logic              rx_on_evt,
    output logic              late_evt
);

    localparam logic [TIME_W:0]   LEAD  = (TIME_W+1)'(WARM_CYC + 2);
    localparam logic [TIME_W-1:0] WARMT = TIME_W'(WARM_CYC);

    trx_state_t        state_q;
    trx_state_t        state_d;
    logic [DLY_W-1:0]  gap_cnt;
    logic [TIME_W-1:0] start_q;
    logic              late_c;
    logic              late_d;
    logic              start_hit;

    // Acceptance of pending commands, only when idle and not forced
    always_comb begin
        acc_tx = (state_q == ST_IDLE) && tx_pend && !force_now;
        acc_rx = (state_q == ST_IDLE) && !tx_pend && rx_pend && !force_now;
    end

    // Lateness test and turn-on instant for a timed receive
    always_comb begin
        late_c    = ({1'b0, rx_time} < ({1'b0, now} + LEAD));
        start_hit = ((now + TIME_W'(1)) >= start_q);
    end

    // Next-state decision
    always_comb begin
        state_d  = state_q;
        rx_enter = 1'b0;
        late_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (acc_tx) begin
                    state_d = ST_TX;
                end else if (acc_rx) begin
                    if (!rxt_pend) begin
                        state_d  = ST_RX;
                        rx_enter = 1'b1;
                    end else if (late_c) begin
                        late_d = 1'b1;
                    end else begin
                        state_d = ST_TWAIT;
                    end
                end
            end
            ST_TX: begin
                if (tx_done) begin
                    state_d = wait_pend ? ST_GAP : ST_IDLE;
                end
            end
            ST_GAP: begin
                if (gap_cnt == '0) begin
                    state_d  = ST_RX;
                    rx_enter = 1'b1;
                end
            end
            ST_TWAIT: begin
                if (start_hit) begin
                    state_d  = ST_RX;
                    rx_enter = 1'b1;
                end
            end
            ST_RX: begin
                if (rx_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (force_now) begin
            state_d  = ST_IDLE;
            rx_enter = 1'b0;
            late_d   = 1'b0;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Reply gap countdown: loaded at transmit end, counted down in the gap
    always_ff @(posedge clk) begin
        if (!rst_n || force_now) begin
            gap_cnt <= '0;
        end else if (state_q == ST_TX && tx_done) begin
            gap_cnt <= resp_dly;
        end else if (state_q == ST_GAP && gap_cnt != '0) begin
            gap_cnt <= gap_cnt - DLY_W'(1);
        end
    end

    // Receiver turn-on time for a timed receive, warm-up ahead of target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (acc_rx && rxt_pend) begin
            start_q <= rx_time - WARMT;
        end
    end

    // Registered event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_on_evt <= 1'b0;
            late_evt  <= 1'b0;
        end else begin
            rx_on_evt <= rx_enter;
            late_evt  <= late_d;
        end
    end

    // Enables decoded from the state register
    always_comb begin
        tx_en = (state_q == ST_TX);
        rx_en = (state_q == ST_RX);
    end

endmodule

// File: rtl/trx_turnaround_seq.sv
// Top of the turnaround sequencer: command bits, sequencer, warm-up counter
// and system time. Assumes tx_done and rx_done are single-cycle strobes from
// the modem and that the host writes one command word per strobe.
module trx_turnaround_seq
    import trx_pkg::*;
#(
    parameter int TIME_W   = 40,
    parameter int DLY_W    = 16,
    parameter int WARM_CYC = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [4:0]        wr_data,
    input  logic [DLY_W-1:0]  resp_dly,
    input  logic [TIME_W-1:0] rx_time,
    input  logic              tx_done,
    input  logic              rx_done,
    output logic              tx_en,
    output logic              rx_en,
    output logic              rx_ready,
    output logic              rx_on_evt,
    output logic              late_evt,
    output logic [3:0]        ctrl_rd,
    output logic [TIME_W-1:0] sys_time
);

    logic force_now;
    logic tx_pend;
    logic wait_pend;
    logic rx_pend;
    logic rxt_pend;
    logic acc_tx;
    logic acc_rx;
    logic rx_enter;

    trx_systime #(.TIME_W(TIME_W)) u_time (
        .clk   (clk),
        .rst_n (rst_n),
        .now   (sys_time)
    );

    trx_cmd_bits u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .acc_tx    (acc_tx),
        .acc_rx    (acc_rx),
        .rx_enter  (rx_enter),
        .force_now (force_now),
        .tx_pend   (tx_pend),
        .wait_pend (wait_pend),
        .rx_pend   (rx_pend),
        .rxt_pend  (rxt_pend)
    );

    trx_seq_fsm #(
        .TIME_W   (TIME_W),
        .DLY_W    (DLY_W),
        .WARM_CYC (WARM_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_now (force_now),
        .tx_pend   (tx_pend),
        .wait_pend (wait_pend),
        .rx_pend   (rx_pend),
        .rxt_pend  (rxt_pend),
        .tx_done   (tx_done),
        .rx_done   (rx_done),
        .resp_dly  (resp_dly),
        .rx_time   (rx_time),
        .now       (sys_time),
        .acc_tx    (acc_tx),
        .acc_rx    (acc_rx),
        .rx_enter  (rx_enter),
        .tx_en     (tx_en),
        .rx_en     (rx_en),
        .rx_on_evt (rx_on_evt),
        .late_evt  (late_evt)
    );

    trx_warmup #(.WARM_CYC(WARM_CYC)) u_warm (
        .clk   (clk),
        .rst_n (rst_n),
        .rx_on (rx_en),
        .ready (rx_ready)
    );

    // Readback of the pending command bits in write-port positions
    always_comb begin
        ctrl_rd          = '0;
        ctrl_rd[CB_TX]     = tx_pend;
        ctrl_rd[CB_WAIT]   = wait_pend;
        ctrl_rd[CB_RX]     = rx_pend;
        ctrl_rd[CB_RXTIME] = rxt_pend;
    end

endmodule

// File: rtl/trx_turnaround_chk.sv
// Temporal checks on the sequencer ports, attached to every instance of the
// top module by the bind below.
module trx_turnaround_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [4:0] wr_data,
    input logic       tx_en,
    input logic       rx_en,
    input logic       rx_ready,
    input logic       rx_on_evt,
    input logic       late_evt,
    input logic [3:0] ctrl_rd
);

    assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_en && rx_en));

    assert_rx_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_en) |-> !$past(tx_en));

    assert_tx_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> !$past(rx_en));

    assert_evt_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_on_evt |-> (rx_en && !$past(rx_en)));

    assert_evt_seen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_en) |-> rx_on_evt);

    assert_ready_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> rx_en);

    assert_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[4]) |=> (!tx_en && !rx_en && ctrl_rd == 4'b0000));

    assert_late_R8: assert property (@(posedge clk) disable iff (!rst_n)
        late_evt |-> !rx_en);

    assert_wait_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[1] && !wr_data[0] && !ctrl_rd[1]) |=> !ctrl_rd[1]);

    assert_wait_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_en) && !$past(wr_en && wr_data[0] && wr_data[1] && !wr_data[4]))
        |-> !ctrl_rd[1]);

endmodule

bind trx_turnaround_seq trx_turnaround_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .tx_en     (tx_en),
    .rx_en     (rx_en),
    .rx_ready  (rx_ready),
    .rx_on_evt (rx_on_evt),
    .late_evt  (late_evt),
    .ctrl_rd   (ctrl_rd)
);

// File: tb/test_trx_turnaround_seq.sv
// Scoreboard bench: the driver queues expected output edges with the cycle in
// which they must appear; a monitor at each falling clock edge pops and compares.
module test_trx_turnaround_seq;

    localparam int CLK_PERIOD = 10;
    localparam int TW   = 40;
    localparam int DW   = 8;
    localparam int WARM = 8;

    localparam int K_TXU  = 0;
    localparam int K_TXD  = 1;
    localparam int K_RXU  = 2;
    localparam int K_RXD  = 3;
    localparam int K_RDU  = 4;
    localparam int K_RDD  = 5;
    localparam int K_LATE = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_data = '0;
    logic [DW-1:0] resp_dly = '0;
    logic [TW-1:0] rx_time = '0;
    logic          tx_done = 1'b0;
    logic          rx_done = 1'b0;
    logic          tx_en, rx_en, rx_ready, rx_on_evt, late_evt;
    logic [3:0]    ctrl_rd;
    logic [TW-1:0] sys_time;

    trx_turnaround_seq #(.TIME_W(TW), .DLY_W(DW), .WARM_CYC(WARM)) i_trx_turnaround_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .resp_dly(resp_dly), .rx_time(rx_time), .tx_done(tx_done), .rx_done(rx_done),
        .tx_en(tx_en), .rx_en(rx_en), .rx_ready(rx_ready), .rx_on_evt(rx_on_evt),
        .late_evt(late_evt), .ctrl_rd(ctrl_rd), .sys_time(sys_time)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int    kind;
        int    at;
        string req;
    } ev_t;

    ev_t           sbq[$];
    int            cyc = 0;
    int            n_vec = 0;
    int            n_bad = 0;
    bit            mon_on = 1'b0;
    bit            done = 1'b0;
    bit            tgt_valid = 1'b0;
    logic [TW-1:0] tgt = '0;
    logic          p_tx = 1'b0, p_rx = 1'b0, p_rdy = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic expect_ev(input int kind, input int at, input string req);
        ev_t e;
        e.kind = kind;
        e.at   = at;
        e.req  = req;
        sbq.push_back(e);
    endtask

    task automatic pop_cmp(input int kind);
        ev_t e;
        n_vec++;
        if (sbq.size() == 0) begin
            n_bad++;
            $display("FAIL R10 unscheduled edge: actual kind %0d at cycle %0d expected none", kind, cyc);
        end else begin
            e = sbq.pop_front();
            if (e.kind != kind || e.at != cyc) begin
                n_bad++;
                $display("FAIL %s edge: actual kind %0d at cycle %0d expected kind %0d at cycle %0d",
                         e.req, kind, cyc, e.kind, e.at);
            end
        end
    endtask

    // Monitor: compare every output edge against the scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            if (tx_en !== p_tx) pop_cmp(tx_en ? K_TXU : K_TXD);
            if (rx_en !== p_rx) pop_cmp(rx_en ? K_RXU : K_RXD);
            if (rx_ready !== p_rdy) begin
                pop_cmp(rx_ready ? K_RDU : K_RDD);
                if (rx_ready && tgt_valid) begin
                    chk("R7 ready time", 64'(sys_time), 64'(tgt));
                    tgt_valid = 1'b0;
                end
            end
            if (late_evt) pop_cmp(K_LATE);
            if (rx_on_evt || (rx_en && !p_rx)) chk("R11 entry pulse", 64'(rx_on_evt), 64'(rx_en && !p_rx));
            if (tx_en && rx_en) chk("R10 overlap", 64'(1), 64'(0));
            p_tx  = tx_en;
            p_rx  = rx_en;
            p_rdy = rx_ready;
        end
    end

    task automatic do_wr(input logic [4:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic pulse_tx();
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic pulse_rx();
        rx_done = 1'b1;
        @(negedge clk);
        rx_done = 1'b0;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R10 watchdog: actual cycle %0d expected run complete", cyc);
            finish_run();
        end
    end

    // Driver
    initial begin
        int x, t, r;
        logic [TW-1:0] s;
        idle(4);
        chk("R10 reset tx_en", 64'(tx_en), 0);
        chk("R10 reset rx_en", 64'(rx_en), 0);
        chk("R10 reset ready", 64'(rx_ready), 0);
        chk("R10 reset ctrl", 64'(ctrl_rd), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        idle(3);

        // R7: time base runs one per clock
        s = sys_time;
        idle(10);
        chk("R7 time step", 64'(sys_time - s), 10);

        // R1: plain transmit
        x = cyc;
        expect_ev(K_TXU, x + 2, "R1");
        do_wr(5'b00001);
        chk("R1 tx bit pending", 64'(ctrl_rd), 1);
        idle(1);
        chk("R1 tx bit cleared", 64'(ctrl_rd), 0);
        wait_to(x + 6);
        t = cyc;
        expect_ev(K_TXD, t + 1, "R1");
        pulse_tx();
        idle(8);

        // R2: wait bit alone is ignored, also when written during transmit
        do_wr(5'b00010);
        chk("R2 lone wait bit", 64'(ctrl_rd), 0);
        x = cyc;
        expect_ev(K_TXU, x + 2, "R2");
        do_wr(5'b00001);
        idle(1);
        do_wr(5'b00010);
        chk("R2 wait during tx", 64'(ctrl_rd), 0);
        t = cyc;
        expect_ev(K_TXD, t + 1, "R2");
        pulse_tx();
        idle(6);
        chk("R2 no turnaround", 64'(rx_en), 0);

        // R3/R4/R6: turnaround with zero gap
        resp_dly = 8'd0;
        x = cyc;
        expect_ev(K_TXU, x + 2, "R3");
        do_wr(5'b00011);
        chk("R4 wait bit set", 64'(ctrl_rd[1]), 1);
        wait_to(x + 6);
        t = cyc;
        expect_ev(K_TXD, t + 1, "R3");
        expect_ev(K_RXU, t + 2, "R3");
        expect_ev(K_RDU, t + 2 + WARM, "R6");
        pulse_tx();
        chk("R4 wait bit held", 64'(ctrl_rd[1]), 1);
        idle(1);
        chk("R4 wait bit cleared", 64'(ctrl_rd[1]), 0);
        wait_to(t + WARM + 5);
        r = cyc;
        expect_ev(K_RXD, r + 1, "R6");
        expect_ev(K_RDD, r + 1, "R6");
        pulse_rx();
        idle(4);

        // R3: turnaround with a five-clock gap
        resp_dly = 8'd5;
        x = cyc;
        expect_ev(K_TXU, x + 2, "R3");
        do_wr(5'b00011);
        wait_to(x + 5);
        t = cyc;
        expect_ev(K_TXD, t + 1, "R3");
        expect_ev(K_RXU, t + 7, "R3");
        expect_ev(K_RDU, t + 7 + WARM, "R6");
        pulse_tx();
        wait_to(t + 6);
        chk("R3 still in gap", 64'(rx_en), 0);
        wait_to(t + 7 + WARM + 2);
        r = cyc;
        expect_ev(K_RXD, r + 1, "R6");
        expect_ev(K_RDD, r + 1, "R6");
        pulse_rx();
        idle(4);

        // R5/R6: immediate receive ended before warm-up
        x = cyc;
        expect_ev(K_RXU, x + 2, "R5");
        do_wr(5'b00100);
        chk("R5 rx bit pending", 64'(ctrl_rd), 4);
        idle(1);
        chk("R5 rx bit cleared", 64'(ctrl_rd), 0);
        wait_to(x + 4);
        r = cyc;
        expect_ev(K_RXD, r + 1, "R6");
        pulse_rx();
        idle(12);

        // R7: timed receive on the lateness boundary
        x = cyc;
        s = sys_time;
        tgt = s + TW'(WARM + 3);
        rx_time = tgt;
        tgt_valid = 1'b1;
        expect_ev(K_RXU, x + 3, "R7");
        expect_ev(K_RDU, x + WARM + 3, "R7");
        do_wr(5'b01100);
        chk("R7 timed bits pending", 64'(ctrl_rd), 12);
        idle(1);
        chk("R7 timed bits cleared", 64'(ctrl_rd), 0);
        wait_to(x + WARM + 6);
        r = cyc;
        expect_ev(K_RXD, r + 1, "R7");
        expect_ev(K_RDD, r + 1, "R7");
        pulse_rx();
        idle(4);

        // R7: timed receive far ahead
        x = cyc;
        s = sys_time;
        tgt = s + TW'(40);
        rx_time = tgt;
        tgt_valid = 1'b1;
        expect_ev(K_RXU, x + 40 - WARM, "R7");
        expect_ev(K_RDU, x + 40, "R7");
        do_wr(5'b01100);
        wait_to(x + 40 - WARM - 1);
        chk("R7 idle before turn-on", 64'(rx_en), 0);
        wait_to(x + 43);
        r = cyc;
        expect_ev(K_RXD, r + 1, "R7");
        expect_ev(K_RDD, r + 1, "R7");
        pulse_rx();
        idle(4);

        // R8: one cycle too late, then a time already past
        x = cyc;
        s = sys_time;
        rx_time = s + TW'(WARM + 2);
        expect_ev(K_LATE, x + 2, "R8");
        do_wr(5'b01100);
        idle(1);
        chk("R8 bits cleared", 64'(ctrl_rd), 0);
        idle(15);
        chk("R8 receiver off", 64'(rx_en), 0);
        x = cyc;
        rx_time = sys_time - TW'(5);
        expect_ev(K_LATE, x + 2, "R8");
        do_wr(5'b01100);
        idle(10);

        // R9: force idle with other bits set does nothing else
        do_wr(5'b10101);
        chk("R9 masked bits", 64'(ctrl_rd), 0);
        idle(6);
        chk("R9 still idle", 64'(tx_en | rx_en), 0);

        // R9: force during transmit with wait armed
        resp_dly = 8'd3;
        x = cyc;
        expect_ev(K_TXU, x + 2, "R9");
        do_wr(5'b00011);
        wait_to(x + 4);
        t = cyc;
        expect_ev(K_TXD, t + 1, "R9");
        do_wr(5'b10000);
        chk("R9 bits cleared in tx", 64'(ctrl_rd), 0);
        idle(2);
        pulse_tx();
        idle(10);

        // R9: force during the reply gap
        resp_dly = 8'd20;
        x = cyc;
        expect_ev(K_TXU, x + 2, "R9");
        do_wr(5'b00011);
        wait_to(x + 4);
        t = cyc;
        expect_ev(K_TXD, t + 1, "R9");
        pulse_tx();
        wait_to(t + 6);
        do_wr(5'b10000);
        chk("R9 bits cleared in gap", 64'(ctrl_rd), 0);
        wait_to(t + 30);
        chk("R9 gap abandoned", 64'(rx_en), 0);

        // R9: force during a timed wait
        x = cyc;
        rx_time = sys_time + TW'(60);
        do_wr(5'b01100);
        wait_to(x + 10);
        do_wr(5'b10000);
        wait_to(x + 70);
        chk("R9 timed wait abandoned", 64'(rx_en), 0);

        // R12: receive queued behind a transmit
        x = cyc;
        expect_ev(K_TXU, x + 2, "R12");
        do_wr(5'b00001);
        wait_to(x + 3);
        do_wr(5'b00100);
        chk("R12 rx pending while busy", 64'(ctrl_rd), 4);
        t = cyc;
        expect_ev(K_TXD, t + 1, "R12");
        expect_ev(K_RXU, t + 2, "R12");
        pulse_tx();
        wait_to(t + 4);
        r = cyc;
        expect_ev(K_RXD, r + 1, "R12");
        pulse_rx();
        idle(4);

        // R12: transmit and receive in one write, transmit first
        x = cyc;
        expect_ev(K_TXU, x + 2, "R12");
        do_wr(5'b00101);
        idle(1);
        chk("R12 rx left pending", 64'(ctrl_rd), 4);
        t = cyc;
        expect_ev(K_TXD, t + 1, "R12");
        expect_ev(K_RXU, t + 2, "R12");
        pulse_tx();
        wait_to(t + 4);
        r = cyc;
        expect_ev(K_RXD, r + 1, "R12");
        pulse_rx();
        idle(6);

        while (sbq.size() > 0) begin
            ev_t e;
            e = sbq.pop_front();
            n_vec++;
            n_bad++;
            $display("FAIL %s missing edge: actual none expected kind %0d at cycle %0d", e.req, e.kind, e.at);
        end
        done = 1'b1;
        finish_run();
    end

endmodule